// File: doc/BRIEF.md
# Output Termination Fault Detector with Peak Capture

This block decides whether each leg of a differential line-driver output is properly terminated. It receives two 5-bit amplitude counts, one for the true leg and one for the complement leg. Each count is compared with a termination threshold, and the threshold in use depends on the current edge-rate setting. A count that rises above the threshold means the leg sees too little load, and the block raises a fault flag for that leg. The flags are kept low while the driver is off, and they stay low after each enable until a programmable settling period has passed.

A second function tracks the extreme value of one count. A 3-bit command picks the mode. It can reseed a shared peak register for maximum or minimum tracking, or it can make the register follow the true-leg count or the complement-leg count. Two readback outputs normally show the live counts. While a capture command is applied to a leg, that leg's readback shows the held peak.

The threshold fields, the rate bit, the enable and the command all come from register storage held elsewhere. They arrive here as plain inputs.

Top module: `term_fault_monitor`

## Requirements
- R1: After reset both fault flags are 0, the peak register holds 0 in maximum mode, and both readbacks show their live counts.
- R2: With the rate bit at 0 the threshold is the 4-bit value {hd_thr_hi, hd_thr_lsb}, which defaults to 4'b1000. With the rate bit at 1 it is {sd_thr_hi, sd_thr_lsb}, which defaults to 4'b0100.
- R3: At each clock edge a leg's fault flag is set to 1 when that leg's count is strictly greater than twice the selected threshold. Otherwise it is set to 0. Each leg is judged on its own count only.
- R4: While drv_enable is 0, both flags are 0 from the next edge onward, whatever the counts are, and the settle counter restarts.
- R5: After drv_enable rises, both flags stay 0 through the first SETTLE_CYCLES edges. A flag can first become 1 at edge SETTLE_CYCLES+1.
- R6: Command 3'b000 reseeds the peak to 0, selects maximum mode, and makes both readbacks show their live counts.
- R7: Command 3'b001 tracks the true-leg count. rd_true shows the peak register and rd_comp stays live. In maximum mode the peak takes the count whenever the count exceeds it.
- R8: Command 3'b010 tracks the complement-leg count in the same way. rd_comp shows the peak and rd_true stays live.
- R9: Command 3'b101 reseeds the peak to 5'h1F, selects minimum mode, and leaves both readbacks live.
- R10: In minimum mode a capture command replaces the peak whenever the tracked count is smaller than it.
- R11: The reserved codes 3'b011, 3'b100, 3'b110 and 3'b111 act exactly like 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_enable | input | 1 | Effective output driver enable |
| rate_sd | input | 1 | Effective edge-rate bit (0 selects the HD threshold, 1 selects the SD threshold) |
| hd_thr_hi | input | 3 | Upper three bits of the HD threshold |
| hd_thr_lsb | input | 1 | Least significant bit of the HD threshold |
| sd_thr_hi | input | 3 | Upper three bits of the SD threshold |
| sd_thr_lsb | input | 1 | Least significant bit of the SD threshold |
| cnt_true | input | 5 | Amplitude count for the true leg |
| cnt_comp | input | 5 | Amplitude count for the complement leg |
| cmd | input | 3 | Compare command |
| fault_true | output | 1 | Termination fault flag for the true leg |
| fault_comp | output | 1 | Termination fault flag for the complement leg |
| rd_true | output | 5 | Readback for the true leg: live count or peak |
| rd_comp | output | 5 | Readback for the complement leg: live count or peak |

## Verification
The hardest situation to reach is a reserved command that arrives after minimum tracking. Left alone, the register would be in minimum mode with a nonzero peak. To get there, the stimulus first reseeds with 101 and captures a small count, so the peak holds a low value in minimum mode. It then applies the reserved code and captures a larger count. Only a correct reseed to maximum mode from zero yields the larger value. The settle window gets the same edge-exact treatment: the bench counts edges after each enable and checks the flags on both sides of the boundary.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

  localparam logic [2:0] CMD_LIVE  = 3'b000;
  localparam logic [2:0] CMD_CAP_T = 3'b001;
  localparam logic [2:0] CMD_CAP_C = 3'b010;
  localparam logic [2:0] CMD_MIN   = 3'b101;

  typedef enum logic {PK_MAX = 1'b0, PK_MIN = 1'b1} peak_mode_e;

  typedef struct packed {
    logic seed_max;
    logic seed_min;
    logic cap_t;
    logic cap_c;
  } cmd_dec_t;

  // Reserved codes fall into the max-seed case.
  function automatic cmd_dec_t decode_cmd(input logic [2:0] c);
    cmd_dec_t d;
    d.cap_t    = (c == CMD_CAP_T);
    d.cap_c    = (c == CMD_CAP_C);
    d.seed_min = (c == CMD_MIN);
    d.seed_max = !(d.cap_t || d.cap_c || d.seed_min);
    return d;
  endfunction

endpackage

// File: rtl/tfm_settle.sv
module tfm_settle #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic armed
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SETTLE_CYCLES);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          done;

  assign done = (cnt_q == LIMIT);

  always_comb begin
    if (!enable)   cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign armed = enable && done;

  assert_settle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  assert_settle_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));
endmodule

// File: rtl/tfm_fault_cmp.sv
module tfm_fault_cmp #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thr,
  output logic             flag
);
  localparam int W = (CNT_W > THR_W + 1) ? CNT_W : THR_W + 1;

  logic [W-1:0] cnt_x, lim_x;
  logic         flag_d;

  assign cnt_x  = W'(count);
  assign lim_x  = W'({thr, 1'b0});
  assign flag_d = arm && (cnt_x > lim_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  assert_quiet_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !flag);
  assert_no_fault_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (W'(count) <= W'({thr, 1'b0})) |=> !flag);
endmodule

// File: rtl/tfm_peak.sv
module tfm_peak
  import tfm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic [CNT_W-1:0] cnt_true,
  input  logic [CNT_W-1:0] cnt_comp,
  output logic [CNT_W-1:0] rd_true,
  output logic [CNT_W-1:0] rd_comp
);
  localparam logic [CNT_W-1:0] TOP = '1;

  cmd_dec_t         dec;
  peak_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] peak_q, peak_d, sel;
  logic             better, peak_en;

  assign dec    = decode_cmd(cmd);
  assign sel    = dec.cap_c ? cnt_comp : cnt_true;
  assign better = (mode_q == PK_MAX) ? (sel > peak_q) : (sel < peak_q);

  always_comb begin
    peak_en = 1'b1;
    peak_d  = peak_q;
    mode_d  = mode_q;
    if (dec.seed_max) begin
      peak_d = '0;
      mode_d = PK_MAX;
    end else if (dec.seed_min) begin
      peak_d = TOP;
      mode_d = PK_MIN;
    end else begin
      peak_en = better;
      peak_d  = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      mode_q <= PK_MAX;
    end else if (peak_en) begin
      peak_q <= peak_d;
      mode_q <= mode_d;
    end
  end

  assign rd_true = dec.cap_t ? peak_q : cnt_true;
  assign rd_comp = dec.cap_c ? peak_q : cnt_comp;

  assert_min_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MIN) |=> (peak_q == TOP && mode_q == PK_MIN));
  assert_reserved_seed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b011 || cmd == 3'b100 || cmd[2:1] == 2'b11) |=> (peak_q == '0 && mode_q == PK_MAX));
  assert_max_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_CAP_T || cmd == CMD_CAP_C) && mode_q == PK_MAX) |=> (peak_q >= $past(peak_q)));
  assert_min_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_CAP_T || cmd == CMD_CAP_C) && mode_q == PK_MIN) |=> (peak_q <= $past(peak_q)));
endmodule

// File: rtl/term_fault_monitor.sv
module term_fault_monitor #(
  parameter int CNT_W         = 5,
  parameter int THR_W         = 4,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_enable,
  input  logic             rate_sd,
  input  logic [THR_W-2:0] hd_thr_hi,
  input  logic             hd_thr_lsb,
  input  logic [THR_W-2:0] sd_thr_hi,
  input  logic             sd_thr_lsb,
  input  logic [CNT_W-1:0] cnt_true,
  input  logic [CNT_W-1:0] cnt_comp,
  input  logic [2:0]       cmd,
  output logic             fault_true,
  output logic             fault_comp,
  output logic [CNT_W-1:0] rd_true,
  output logic [CNT_W-1:0] rd_comp
);
  localparam int LEGS = 2;

  logic             armed;
  logic [THR_W-1:0] thr_sel;
  logic [CNT_W-1:0] leg_cnt [LEGS];
  logic [LEGS-1:0]  leg_flag;

  assign thr_sel    = rate_sd ? {sd_thr_hi, sd_thr_lsb} : {hd_thr_hi, hd_thr_lsb};
  assign leg_cnt[0] = cnt_true;
  assign leg_cnt[1] = cnt_comp;

  tfm_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .enable(drv_enable), .armed(armed)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    tfm_fault_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .arm(armed),
      .count(leg_cnt[g]), .thr(thr_sel), .flag(leg_flag[g])
    );
  end

  assign fault_true = leg_flag[0];
  assign fault_comp = leg_flag[1];

  tfm_peak #(.CNT_W(CNT_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .cnt_true(cnt_true), .cnt_comp(cnt_comp),
    .rd_true(rd_true), .rd_comp(rd_comp)
  );

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_enable |=> (!fault_true && !fault_comp));
endmodule

// File: tb/test_term_fault_monitor.sv
module test_term_fault_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       drv_enable, rate_sd, hd_thr_lsb, sd_thr_lsb;
  logic [2:0] hd_thr_hi, sd_thr_hi, cmd;
  logic [4:0] cnt_true, cnt_comp, rd_true, rd_comp;
  logic       fault_true, fault_comp;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  term_fault_monitor #(.SETTLE_CYCLES(SETTLE)) i_term_fault_monitor (
    .clk(clk), .rst_n(rst_n), .drv_enable(drv_enable), .rate_sd(rate_sd),
    .hd_thr_hi(hd_thr_hi), .hd_thr_lsb(hd_thr_lsb),
    .sd_thr_hi(sd_thr_hi), .sd_thr_lsb(sd_thr_lsb),
    .cnt_true(cnt_true), .cnt_comp(cnt_comp), .cmd(cmd),
    .fault_true(fault_true), .fault_comp(fault_comp),
    .rd_true(rd_true), .rd_comp(rd_comp)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    drv_enable = 0; rate_sd = 0; cmd = 3'b000;
    hd_thr_hi = 3'b100; hd_thr_lsb = 0; sd_thr_hi = 3'b010; sd_thr_lsb = 0;
    cnt_true = 5'd21; cnt_comp = 5'd30;
    rst_n = 0;
    step(3);
    check("R1 fault_true", fault_true, 0);
    check("R1 fault_comp", fault_comp, 0);
    rst_n = 1;
    step(1);
    check("R1 rd_true live", rd_true, 21);
    check("R1 rd_comp live", rd_comp, 30);
    cmd = 3'b001; cnt_true = 5'd0;
    step(1);
    check("R1 peak seeded 0", rd_true, 0);
    cmd = 3'b000;
  endtask

  task automatic t_settle;
    cnt_true = 5'd20; cnt_comp = 5'd20; drv_enable = 1;
    step(SETTLE);
    check("R5 true held at window end", fault_true, 0);
    check("R5 comp held at window end", fault_comp, 0);
    step(1);
    check("R5 true after window", fault_true, 1);
    check("R5 comp after window", fault_comp, 1);
  endtask

  task automatic t_threshold;
    cnt_true = 5'd16; cnt_comp = 5'd17;
    step(1);
    check("R3 equal to 2*thr no fault", fault_true, 0);
    check("R3 above 2*thr fault", fault_comp, 1);
    rate_sd = 1; cnt_true = 5'd9; cnt_comp = 5'd8;
    step(1);
    check("R2 sd threshold true", fault_true, 1);
    check("R2 sd threshold comp", fault_comp, 0);
    rate_sd = 0; hd_thr_hi = 3'b011; hd_thr_lsb = 1; cnt_true = 5'd15; cnt_comp = 5'd14;
    step(1);
    check("R2 hd lsb used true", fault_true, 1);
    check("R2 hd lsb used comp", fault_comp, 0);
    hd_thr_hi = 3'b100; hd_thr_lsb = 0; cnt_true = 5'd16;
    step(1);
    check("R3 deassert", fault_true, 0);
  endtask

  task automatic t_disable;
    cnt_true = 5'd31; cnt_comp = 5'd31; drv_enable = 0;
    step(1);
    check("R4 true quiet disabled", fault_true, 0);
    check("R4 comp quiet disabled", fault_comp, 0);
    drv_enable = 1;
    step(SETTLE);
    check("R4 settle restarted", fault_true, 0);
    step(1);
    check("R4 fault after re-settle", fault_true, 1);
  endtask

  task automatic t_max_true;
    int seq[4] = '{5, 12, 7, 3};
    int expv[4] = '{5, 12, 12, 12};
    cmd = 3'b000;
    step(1);
    cmd = 3'b001;
    for (int i = 0; i < 4; i++) begin
      cnt_true = 5'(seq[i]); cnt_comp = 5'(i + 1);
      step(1);
      check("R7 max peak true", rd_true, expv[i]);
      check("R7 comp live", rd_comp, i + 1);
    end
  endtask

  task automatic t_max_comp;
    int seq[3] = '{4, 9, 2};
    int expv[3] = '{4, 9, 9};
    cmd = 3'b000; cnt_true = 5'd13; cnt_comp = 5'd6;
    step(1);
    check("R6 true live", rd_true, 13);
    check("R6 comp live", rd_comp, 6);
    cmd = 3'b010;
    for (int i = 0; i < 3; i++) begin
      cnt_comp = 5'(seq[i]); cnt_true = 5'(20 + i);
      step(1);
      check("R8 max peak comp", rd_comp, expv[i]);
      check("R8 true live", rd_true, 20 + i);
    end
  endtask

  task automatic t_min;
    int seq[4] = '{20, 25, 6, 11};
    int expv[4] = '{20, 20, 6, 6};
    cmd = 3'b101; cnt_true = 5'd2; cnt_comp = 5'd3;
    step(1);
    check("R9 true live", rd_true, 2);
    check("R9 comp live", rd_comp, 3);
    cmd = 3'b001;
    for (int i = 0; i < 4; i++) begin
      cnt_true = 5'(seq[i]);
      step(1);
      check("R10 min peak", rd_true, expv[i]);
    end
  endtask

  task automatic t_reserved;
    logic [2:0] codes[4] = '{3'b011, 3'b100, 3'b110, 3'b111};
    for (int i = 0; i < 4; i++) begin
      cmd = 3'b101; step(1);
      cmd = 3'b001; cnt_true = 5'd4; step(1);
      cmd = codes[i]; cnt_true = 5'd17; cnt_comp = 5'd18;
      step(1);
      check("R11 reserved true live", rd_true, 17);
      check("R11 reserved comp live", rd_comp, 18);
      cmd = 3'b001; cnt_true = 5'd9;
      step(1);
      check("R11 reseeded max", rd_true, 9);
    end
    cmd = 3'b000;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_settle();
        t_threshold();
        t_disable();
        t_max_true();
        t_max_comp();
        t_min();
        t_reserved();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule